// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 32x32 pointer image over a video pixel stream. Two bit planes, an image plane and a shape plane, sit side by side in a small byte-wide cursor memory. The host loads that memory by setting a pointer and then streaming bytes; the pointer steps by one after every byte. The host also sets the cursor position, a three-entry overlay colour table and a two-bit cursor mode, all through one register write port.

The cursor position names the rightmost column and the lowest row of the cursor window, not its top-left corner. The block counts columns and rows itself from frame, line and pixel strobes. For each pixel inside the window it looks up the two plane bits and either keeps the incoming pixel or replaces it with an overlay colour, following the selected mode. Pixels flagged as outside the active area take the overscan colour. Position changes take effect at the next frame start, so the cursor never tears partway through a frame.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix_out` and `out_valid` are 0, the mode is off, and every colour entry and position is 0.
- R2: A write to register code 0 sets the 8-bit memory pointer. A write to code 1 stores `reg_wdata[7:0]` at the pointer and then advances the pointer by one, wrapping from 255 to 0.
- R3: Memory bytes 0..127 hold the image plane and bytes 128..255 hold the shape plane. Cursor row r, column c lives in byte r*4 + c/8 of each plane, at bit 7 - (c mod 8), so the most significant bit is the leftmost pixel.
- R4: `frame_start` sets the raster row and column to 0. `line_start` adds one to the row and clears the column. Each `pix_valid` pixel is at the current column, and the column then advances. With X and Y the applied positions, the window covers columns X-31..X and rows Y-31..Y, and cursor pixel (r, c) corresponds to raster (Y-31+r, X-31+c). Window parts at negative coordinates are clipped. Active pixels outside the window pass through unchanged.
- R5: Mode 3: where the shape bit is 0 the input pixel passes. Where it is 1, the pixel becomes the foreground colour (code 7) if the image bit is 1, or the background colour (code 6) if it is 0.
- R6: Mode 2 behaves as mode 3, except that where the shape bit is 0 and the image bit is 1 the bitwise inverse of the input pixel is output.
- R7: Mode 1: where the image bit is 1 the foreground colour is output, otherwise the input pixel. The shape bit is ignored.
- R8: Mode 0 (mode register code 4, bits 1:0) disables the cursor, and every active pixel passes unchanged.
- R9: A pixel with `active` low is output as the overscan colour (code 5), whatever the cursor state.
- R10: X (code 2) and Y (code 3) are 12-bit values. Writes to them are held pending and only become the applied position on the next `frame_start`.
- R11: Output latency is one cycle: `out_valid` equals `pix_valid` of the previous cycle, and `pix_out` holds the result for that pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register code: 0 pointer, 1 memory data, 2 X, 3 Y, 4 mode, 5..7 colour entries 0..2 |
| reg_wdata | input | 24 | Register write data |
| frame_start | input | 1 | Start-of-frame strobe |
| line_start | input | 1 | Start-of-line strobe |
| pix_valid | input | 1 | Input pixel qualifier |
| active | input | 1 | Pixel lies in the active display area |
| pix_in | input | 24 | Incoming pixel colour |
| pix_out | output | 24 | Overlaid pixel colour |
| out_valid | output | 1 | `pix_out` qualifier |

## Verification
A wrong pointer or a misplaced memory byte shows up as a wrong overlay colour at a precise raster pixel. It appears on the first line that crosses the affected cursor row, one cycle after that pixel enters. A miscounted raster column or row shifts the whole window and breaks the edge pixels at columns X-31 and X on the first cursor line. A position register that is applied early changes pixels within the same frame, and the bench makes this visible by checking a line drawn between a position write and the next frame start.

// File: rtl/cur_pkg.sv
package cur_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_MASK = 2'd1,
      MODE_INV  = 2'd2,
      MODE_FULL = 2'd3
   } cur_mode_e;

   localparam logic [2:0] RA_PTR  = 3'd0;
   localparam logic [2:0] RA_DATA = 3'd1;
   localparam logic [2:0] RA_XPOS = 3'd2;
   localparam logic [2:0] RA_YPOS = 3'd3;
   localparam logic [2:0] RA_MODE = 3'd4;
   localparam logic [2:0] RA_CLR0 = 3'd5;
   localparam int CLR_ENTRIES = 3;
endpackage

// File: rtl/cur_raster.sv
module cur_raster #(
   parameter int COORD_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               line_start,
   input  logic               pix_valid,
   output logic [COORD_W-1:0] col,
   output logic [COORD_W-1:0] row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (frame_start) begin
         col <= '0;
         row <= '0;
      end else if (line_start) begin
         col <= '0;
         row <= row + 1'b1;
      end else if (pix_valid) begin
         col <= col + 1'b1;
      end
   end
endmodule

// File: rtl/cur_map_ram.sv
module cur_map_ram #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_we,
   input  logic          data_we,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] rd_a_addr,
   input  logic [AW-1:0] rd_b_addr,
   output logic [7:0]    rd_a,
   output logic [7:0]    rd_b,
   output logic [AW-1:0] ptr
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (ptr_we)  ptr <= wdata[AW-1:0];
      else if (data_we) ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (data_we) mem[ptr] <= wdata;
   end

   assign rd_a = mem[rd_a_addr];
   assign rd_b = mem[rd_b_addr];
endmodule

// File: rtl/cur_mixer.sv
module cur_mixer
   import cur_pkg::*;
#(
   parameter int COLOR_W = 24,
   parameter int COORD_W = 12,
   parameter int CUR_DIM = 32,
   parameter int AW      = 8
) (
   input  logic [COORD_W-1:0] col,
   input  logic [COORD_W-1:0] row,
   input  logic [COORD_W-1:0] x_pos,
   input  logic [COORD_W-1:0] y_pos,
   input  cur_mode_e          mode,
   input  logic               active,
   input  logic [COLOR_W-1:0] pix_in,
   input  logic [COLOR_W-1:0] clr_ovs,
   input  logic [COLOR_W-1:0] clr_bg,
   input  logic [COLOR_W-1:0] clr_fg,
   input  logic [7:0]         img_byte,
   input  logic [7:0]         shp_byte,
   output logic [AW-1:0]      img_addr,
   output logic [AW-1:0]      shp_addr,
   output logic [COLOR_W-1:0] mix_pix
);
   localparam int IW = $clog2(CUR_DIM);
   localparam logic [COORD_W:0] DIM_W = (COORD_W+1)'(CUR_DIM);

   logic [COORD_W:0] dx, dy;
   logic             in_win;
   logic [IW-1:0]    cx, cy;
   logic [2:0]       bsel;
   logic             img_bit, shp_bit;

   // distance back from the right/bottom edge of the window
   assign dx     = {1'b0, x_pos} - {1'b0, col};
   assign dy     = {1'b0, y_pos} - {1'b0, row};
   assign in_win = !dx[COORD_W] && (dx < DIM_W) && !dy[COORD_W] && (dy < DIM_W);
   assign cx     = IW'(CUR_DIM - 1) - dx[IW-1:0];
   assign cy     = IW'(CUR_DIM - 1) - dy[IW-1:0];

   assign img_addr = {1'b0, cy, cx[IW-1:3]};
   assign shp_addr = {1'b1, cy, cx[IW-1:3]};
   assign bsel     = 3'd7 - cx[2:0];
   assign img_bit  = img_byte[bsel];
   assign shp_bit  = shp_byte[bsel];

   always_comb begin
      mix_pix = pix_in;
      if (!active) begin
         mix_pix = clr_ovs;
      end else if (in_win) begin
         unique case (mode)
            MODE_FULL: if (shp_bit) mix_pix = img_bit ? clr_fg : clr_bg;
            MODE_INV: begin
               if (shp_bit)      mix_pix = img_bit ? clr_fg : clr_bg;
               else if (img_bit) mix_pix = ~pix_in;
            end
            MODE_MASK: if (img_bit) mix_pix = clr_fg;
            default:   mix_pix = pix_in;
         endcase
      end
   end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
   import cur_pkg::*;
#(
   parameter int COLOR_W = 24,
   parameter int COORD_W = 12,
   parameter int CUR_DIM = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [2:0]         reg_addr,
   input  logic [COLOR_W-1:0] reg_wdata,
   input  logic               frame_start,
   input  logic               line_start,
   input  logic               pix_valid,
   input  logic               active,
   input  logic [COLOR_W-1:0] pix_in,
   output logic [COLOR_W-1:0] pix_out,
   output logic               out_valid
);
   localparam int MAP_BYTES = CUR_DIM * CUR_DIM / 8;
   localparam int AW        = $clog2(2 * MAP_BYTES);

   if ((CUR_DIM < 8) || ((CUR_DIM & (CUR_DIM - 1)) != 0)) begin : g_bad_dim
      $error("CUR_DIM must be a power of two of at least 8");
   end
   if ((COLOR_W < 8) || (COLOR_W < COORD_W)) begin : g_bad_width
      $error("COLOR_W must cover a byte and a coordinate");
   end

   logic [COORD_W-1:0] x_pend, y_pend, x_act, y_act;
   cur_mode_e          mode_q;
   logic [COLOR_W-1:0] clr_q [CLR_ENTRIES];
   logic [COORD_W-1:0] col, row;
   logic [AW-1:0]      img_addr, shp_addr, ram_ptr;
   logic [7:0]         img_byte, shp_byte;
   logic [COLOR_W-1:0] mix_pix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_pend <= '0;
         y_pend <= '0;
         x_act  <= '0;
         y_act  <= '0;
         mode_q <= MODE_OFF;
         for (int i = 0; i < CLR_ENTRIES; i++) clr_q[i] <= '0;
      end else begin
         if (reg_we && reg_addr == RA_XPOS) x_pend <= reg_wdata[COORD_W-1:0];
         if (reg_we && reg_addr == RA_YPOS) y_pend <= reg_wdata[COORD_W-1:0];
         if (reg_we && reg_addr == RA_MODE) mode_q <= cur_mode_e'(reg_wdata[1:0]);
         for (int i = 0; i < CLR_ENTRIES; i++)
            if (reg_we && reg_addr == RA_CLR0 + 3'(i)) clr_q[i] <= reg_wdata;
         if (frame_start) begin
            x_act <= x_pend;
            y_act <= y_pend;
         end
      end
   end

   cur_raster #(.COORD_W(COORD_W)) u_raster (
      .clk, .rst_n, .frame_start, .line_start, .pix_valid, .col, .row
   );

   cur_map_ram #(.AW(AW)) u_ram (
      .clk, .rst_n,
      .ptr_we   (reg_we && reg_addr == RA_PTR),
      .data_we  (reg_we && reg_addr == RA_DATA),
      .wdata    (reg_wdata[7:0]),
      .rd_a_addr(img_addr),
      .rd_b_addr(shp_addr),
      .rd_a     (img_byte),
      .rd_b     (shp_byte),
      .ptr      (ram_ptr)
   );

   cur_mixer #(.COLOR_W(COLOR_W), .COORD_W(COORD_W), .CUR_DIM(CUR_DIM), .AW(AW)) u_mix (
      .col, .row, .x_pos(x_act), .y_pos(y_act), .mode(mode_q), .active, .pix_in,
      .clr_ovs(clr_q[0]), .clr_bg(clr_q[1]), .clr_fg(clr_q[2]),
      .img_byte, .shp_byte, .img_addr, .shp_addr, .mix_pix
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_out   <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= pix_valid;
         if (pix_valid) pix_out <= mix_pix;
      end
   end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter int COLOR_W = 24,
   parameter int COORD_W = 12,
   parameter int AW      = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [2:0]         reg_addr,
   input logic               frame_start,
   input logic               line_start,
   input logic               pix_valid,
   input logic               active,
   input logic [COLOR_W-1:0] pix_in,
   input logic [COLOR_W-1:0] pix_out,
   input logic               out_valid,
   input logic [1:0]         mode,
   input logic [COORD_W-1:0] x_act,
   input logic [COORD_W-1:0] y_act,
   input logic [AW-1:0]      ram_ptr,
   input logic [COORD_W-1:0] col,
   input logic [COLOR_W-1:0] ovs_clr
);
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);  // R11
   AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);  // R11
   AST_OVERSCAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !active) |=> (pix_out == $past(ovs_clr)));  // R9
   AST_MODE_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && active && mode == 2'd0) |=> (pix_out == $past(pix_in)));  // R8
   AST_POS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(x_act) && $stable(y_act)));  // R10
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd1) |=> (ram_ptr == AW'($past(ram_ptr) + 1'b1)));  // R2
   AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start || frame_start) |=> (col == '0));  // R4
endmodule

bind cursor_overlay cursor_overlay_chk #(
   .COLOR_W(COLOR_W), .COORD_W(COORD_W), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .frame_start(frame_start), .line_start(line_start), .pix_valid(pix_valid),
   .active(active), .pix_in(pix_in), .pix_out(pix_out), .out_valid(out_valid),
   .mode(mode_q), .x_act(x_act), .y_act(y_act), .ram_ptr(ram_ptr), .col(col),
   .ovs_clr(clr_q[0])
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
   localparam int CW = 24;

   logic          clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [CW-1:0] reg_wdata = '0, pix_in = '0;
   logic          frame_start = 1'b0, line_start = 1'b0, pix_valid = 1'b0, active = 1'b0;
   logic [CW-1:0] pix_out;
   logic          out_valid;

   always #5 clk = ~clk;

   cursor_overlay u_cursor_overlay (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .frame_start, .line_start,
      .pix_valid, .active, .pix_in, .pix_out, .out_valid
   );

   int checks = 0, errors = 0;
   logic [7:0]    mem_m [256];
   logic [7:0]    ptr_m = 8'd0;
   int            x_pend = 0, y_pend = 0, x_act = 0, y_act = 0, mode_m = 0, row_m = 0, col_m = 0;
   logic [CW-1:0] clr_m [3] = '{default: '0};
   string         tag_ov = "";

   typedef struct packed {
      logic [1:0]  mode;
      logic [11:0] x;
      logic [11:0] y;
      logic [11:0] row;
      logic [7:0]  ncol;
      logic [7:0]  act_end;
      logic        newfr;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'd3, 12'd40, 12'd35, 12'd4,  8'd48, 8'd48, 1'b1},  // top cursor row
      '{2'd3, 12'd40, 12'd35, 12'd20, 8'd48, 8'd48, 1'b0},
      '{2'd3, 12'd40, 12'd35, 12'd35, 8'd48, 8'd44, 1'b0},  // bottom row, overscan tail
      '{2'd3, 12'd40, 12'd35, 12'd36, 8'd48, 8'd48, 1'b0},  // below window
      '{2'd2, 12'd40, 12'd35, 12'd10, 8'd48, 8'd48, 1'b1},
      '{2'd1, 12'd40, 12'd35, 12'd12, 8'd48, 8'd48, 1'b1},
      '{2'd0, 12'd40, 12'd35, 12'd20, 8'd48, 8'd48, 1'b1},
      '{2'd3, 12'd10, 12'd10, 12'd0,  8'd16, 8'd16, 1'b1},  // clipped corner
      '{2'd3, 12'd10, 12'd10, 12'd8,  8'd16, 8'd16, 1'b0},
      '{2'd3, 12'd20, 12'd30, 12'd9,  8'd40, 8'd40, 1'b0},  // pending move
      '{2'd3, 12'd20, 12'd30, 12'd0,  8'd40, 8'd40, 1'b1}   // move applied
   };

   task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (a)
         3'd0: ptr_m = d[7:0];
         3'd1: begin mem_m[ptr_m] = d[7:0]; ptr_m = ptr_m + 8'd1; end
         3'd2: x_pend = int'(d[11:0]);
         3'd3: y_pend = int'(d[11:0]);
         3'd4: mode_m = int'(d[1:0]);
         default: clr_m[a - 3'd5] = d;
      endcase
   endtask

   task automatic pulse_frame();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      x_act = x_pend; y_act = y_pend; row_m = 0; col_m = 0;
   endtask

   task automatic pulse_line();
      @(negedge clk); line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
      row_m++; col_m = 0;
   endtask

   // Model of R3..R9: plane layout, window placement and mode rules
   function automatic logic [CW-1:0] model(input logic [CW-1:0] p, input logic act, output string tag);
      int dx, dy, c, r;
      logic ib, sb;
      if (!act) begin tag = "R9"; return clr_m[0]; end
      if (mode_m == 0) begin tag = "R8"; return p; end
      dx = x_act - col_m; dy = y_act - row_m;
      if (dx < 0 || dx > 31 || dy < 0 || dy > 31) begin tag = "R4"; return p; end
      c = 31 - dx; r = 31 - dy;
      ib = mem_m[r*4 + c/8][7 - c%8];
      sb = mem_m[128 + r*4 + c/8][7 - c%8];
      case (mode_m)
         3: begin tag = "R5"; return sb ? (ib ? clr_m[2] : clr_m[1]) : p; end
         2: begin tag = "R6"; return sb ? (ib ? clr_m[2] : clr_m[1]) : (ib ? ~p : p); end
         default: begin tag = "R7"; return ib ? clr_m[2] : p; end
      endcase
   endfunction

   task automatic push(input logic [CW-1:0] p, input logic act);
      logic [CW-1:0] exp;
      string tag;
      exp = model(p, act, tag);
      if (tag_ov != "") tag = tag_ov;
      @(negedge clk);
      pix_valid = 1'b1; pix_in = p; active = act;
      @(negedge clk);
      pix_valid = 1'b0;
      chk(tag, pix_out, exp);
      chk("R11", CW'(out_valid), CW'(1));
      col_m++;
   endtask

   function automatic logic [CW-1:0] pixval(input int r, input int c);
      return {8'(r), 8'(c), 8'hA5 ^ 8'(c)};
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, then mode off passes pixels
      chk("R1", pix_out, '0);
      chk("R1", CW'(out_valid), '0);
      tag_ov = "R1";
      push(24'h123456, 1'b1);
      push(24'h0F0F0F, 1'b0);
      tag_ov = "";

      wr(3'd5, 24'h112233);
      wr(3'd6, 24'h0000AA);
      wr(3'd7, 24'hFFEE00);
      // R2 and R3: stream both planes from pointer 0
      wr(3'd0, 24'd0);
      for (int i = 0; i < 256; i++)
         wr(3'd1, CW'(8'(i * 73 + 29) ^ 8'(i >> 2)));

      for (int v = 0; v < NV; v++) begin
         wr(3'd4, CW'(VECS[v].mode));
         tag_ov = (!VECS[v].newfr && (int'(VECS[v].x) != x_act || int'(VECS[v].y) != y_act)) ? "R10" : "";
         wr(3'd2, CW'(VECS[v].x));
         wr(3'd3, CW'(VECS[v].y));
         if (VECS[v].newfr) pulse_frame();
         while (row_m < int'(VECS[v].row)) pulse_line();
         for (int c = 0; c < int'(VECS[v].ncol); c++)
            push(pixval(row_m, c), c < int'(VECS[v].act_end));
      end

      // R2: pointer wraps from 255 to 0
      tag_ov = "R2";
      wr(3'd0, 24'd255);
      wr(3'd1, 24'h00000F);
      wr(3'd1, 24'h0000F0);
      wr(3'd4, 24'd3);
      wr(3'd2, 24'd31);
      wr(3'd3, 24'd31);
      pulse_frame();
      for (int c = 0; c < 32; c++) push(pixval(0, c), 1'b1);
      while (row_m < 31) pulse_line();
      for (int c = 0; c < 32; c++) push(pixval(31, c), 1'b1);
      tag_ov = "";

      @(negedge clk);
      chk("R11", CW'(out_valid), '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule